// File: doc/BRIEF.md
# Fractional Oversample Rate Generator

This block derives the sampling cadence for a serial transmitter and receiver pair. Both sides take their timing from the same two pulses. The first is an oversample tick that fires sixteen times per bit. The second is a bit tick that fires once per bit, in the same cycle as every sixteenth oversample tick.

The rate comes from a 16-bit divisor word. Its upper twelve bits hold the whole part of the divisor and its lower four bits hold sixteenths. A phase accumulator adds 16 on every functional clock and subtracts the divisor word when the sum reaches it. The gap between oversample ticks therefore alternates between the two nearest whole cycle counts, and the average gap equals the fractional divisor. One bit lasts exactly as many clock cycles as the numeric value of the divisor word.

A new divisor word is taken only at an oversample tick, so a running bit is never stretched by a value that changes partway through it. A global enable starts and stops the generator. While the enable is low, the generator holds in a cleared state.

Top module: `baudTickGen`

## Requirements
- R1: The 16-bit word `divReg` encodes the divisor. Bits [15:4] hold the whole part and bits [3:0] hold sixteenths, so the divisor is `divReg`/16. For example, 0x18A means 24.625 and 0x271 means 39.0625.
- R2: Clock edges are counted from 1 at the first edge with `enable` high. Oversample tick number m then rises one cycle wide after edge ceil(m·`divReg`/16). Consecutive ticks are therefore floor or ceil of `divReg`/16 cycles apart.
- R3: `bitTick` is a one-cycle pulse on every 16th oversample tick, always together with `ovTick`. Bit ticks are exactly `divReg` cycles apart.
- R4: When the active divisor word is below 16 (whole part zero), neither tick is produced.
- R5: While `enable` is low, both ticks stay low, and the accumulator and the 1-of-16 counter are cleared. A later rise of `enable` restarts the phase exactly as in R2.
- R6: A new divisor word is sampled only at an edge that produces an oversample tick, or while the generator is disabled or idle. A value present only between ticks has no effect. A value sampled at a bit tick edge starts a fresh phase, so the next bit tick comes exactly the new word's value in cycles later.
- R7: After reset, both outputs are low.
- R8: With `divReg` = 0x010 (divisor 1.0), `ovTick` is high on every cycle and `bitTick` fires every 16 cycles.
- R9: With 0x18A, a bit lasts 394 cycles. With 0x271, a bit lasts 625 cycles, which gives 115200 bit/s from a 72 MHz clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global run enable |
| divReg | input | 16 | Divisor word: whole part [15:4], sixteenths [3:0] |
| ovTick | output | 1 | One-cycle oversample tick |
| bitTick | output | 1 | One-cycle bit tick |

## Verification
The bench builds the generator with its default parameters: a 12-bit whole field, a 4-bit fraction and an oversample factor of 16. With these defaults, the fastest divisor 0x010 is within reach, where a tick arrives on every cycle. The dithering word 0x18A is also within reach, where gaps alternate between 24 and 25 cycles. Each oversample tick is compared with the ceiling formula, and each bit tick is taken from a queue of expected cycle numbers. Those expectations cover a divisor switch at a bit boundary, a one-cycle glitch on the divisor between ticks, a disable partway through a bit, and words below 16.

// File: rtl/rateGenPkg.sv
package rateGenPkg;
  // strobes issued by the control to the accumulator datapath
  typedef struct packed {
    logic clear;   // zero the accumulator
    logic step;    // add one increment this cycle
    logic wrap;    // subtract the active divisor (tick cycle)
    logic reload;  // capture a new divisor word
  } rateStrobes_t;
endpackage

// File: rtl/rateAccum.sv
module rateAccum
  import rateGenPkg::*;
#(
  parameter int DIV_W = 16,
  parameter int STEP  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divIn,
  input  rateStrobes_t     strb,
  output logic             reachFlag,
  output logic             divValid
);
  localparam int ACC_W = DIV_W + 1;

  logic [DIV_W-1:0] activeDiv;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;

  assign sum       = acc + ACC_W'(STEP);
  assign reachFlag = sum >= {1'b0, activeDiv};
  assign divValid  = activeDiv >= DIV_W'(STEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      activeDiv <= '0;
    end else begin
      if (strb.clear) begin
        acc <= '0;
      end else if (strb.step) begin
        acc <= strb.wrap ? (sum - {1'b0, activeDiv}) : sum;
      end
      if (strb.reload) begin
        activeDiv <= divIn;
      end
    end
  end

  // phase never reaches the divisor while running
  assert_acc_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    divValid |-> (acc < {1'b0, activeDiv}));

  // divisor only moves when the control asks for it
  assert_div_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.reload |=> $stable(activeDiv));

endmodule

// File: rtl/rateCtrl.sv
module rateCtrl
  import rateGenPkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         reachFlag,
  input  logic         divValid,
  output rateStrobes_t strb,
  output logic         ovTick,
  output logic         bitTick
);
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;

  logic [CNT_W-1:0] subCnt;
  logic             lastSub;
  logic             running;

  assign running     = enable && divValid;
  assign lastSub     = subCnt == CNT_W'(OVERSAMPLE - 1);
  assign strb.clear  = !running;
  assign strb.step   = running;
  assign strb.wrap   = running && reachFlag;
  assign strb.reload = !running || strb.wrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt  <= '0;
      ovTick  <= 1'b0;
      bitTick <= 1'b0;
    end else begin
      ovTick  <= strb.wrap;
      bitTick <= strb.wrap && lastSub;
      if (strb.clear) begin
        subCnt <= '0;
      end else if (strb.wrap) begin
        subCnt <= lastSub ? '0 : subCnt + 1'b1;
      end
    end
  end

  assert_bit_with_ov_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> ovTick);

  assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!ovTick && !bitTick));

  assert_no_tick_small_R4: assert property (@(posedge clk) disable iff (!rstN)
    !divValid |=> !ovTick);

endmodule

// File: rtl/baudTickGen.sv
module baudTickGen
  import rateGenPkg::*;
#(
  parameter int INT_W      = 12,
  parameter int FRAC_W     = 4,
  parameter int OVERSAMPLE = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic [INT_W+FRAC_W-1:0] divReg,
  output logic                    ovTick,
  output logic                    bitTick
);
  localparam int DIV_W = INT_W + FRAC_W;
  localparam int STEP  = 1 << FRAC_W;

  rateStrobes_t strb;
  logic         reachFlag;
  logic         divValid;

  rateAccum #(.DIV_W(DIV_W), .STEP(STEP)) uAccum (
    .clk       (clk),
    .rstN      (rstN),
    .divIn     (divReg),
    .strb      (strb),
    .reachFlag (reachFlag),
    .divValid  (divValid)
  );

  rateCtrl #(.OVERSAMPLE(OVERSAMPLE)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .reachFlag (reachFlag),
    .divValid  (divValid),
    .strb      (strb),
    .ovTick    (ovTick),
    .bitTick   (bitTick)
  );

endmodule

// File: tb/baudTickGen_test.sv
module baudTickGen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] divReg = 16'h0000;
  logic        ovTick, bitTick;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int origin = 0;
  int curDiv = 0;
  int m = 0;
  int nextDiv = 0;
  bit pending = 0;
  bit quiet = 1;
  bit quietSeen = 0;
  bit running = 0;
  bit done = 0;
  int expQ[$];

  baudTickGen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .divReg(divReg),
    .ovTick(ovTick), .bitTick(bitTick)
  );

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: oversample ticks against the ceiling rule, bit ticks against the queue
  always @(negedge clk) begin
    if (running) begin
      if (ovTick || bitTick) begin
        if (quiet) quietSeen = 1;
      end
      if (ovTick && !quiet) begin
        m++;
        check(cyc == origin + (m * curDiv + 15) / 16, "R2 ovTick cycle", cyc,
              origin + (m * curDiv + 15) / 16);
      end
      if (bitTick && !quiet) begin
        check(ovTick == 1'b1, "R3 bitTick without ovTick", ovTick, 1);
        if (expQ.size() == 0) begin
          check(0, "R3 unexpected bitTick", cyc, -1);
        end else begin
          int e;
          e = expQ.pop_front();
          check(cyc == e, "R3 bitTick cycle", cyc, e);
        end
        if (pending) begin
          origin  = cyc;
          curDiv  = nextDiv;
          m       = 0;
          pending = 0;
        end
      end
    end
  end

  task automatic waitUntil(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic startRun(input int d, input int nBits);
    @(negedge clk);
    divReg = 16'(d);
    @(negedge clk);
    enable = 1'b1;
    quiet  = 0;
    origin = cyc;
    curDiv = d;
    m      = 0;
    for (int k = 1; k <= nBits; k++) expQ.push_back(origin + k * d);
  endtask

  task automatic stopRun();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    quiet = 1;
    quietSeen = 0;
  endtask

  task automatic quietCheck(input int cycles, input string req);
    repeat (cycles) @(negedge clk);
    check(quietSeen == 0, req, quietSeen, 0);
    quietSeen = 0;
  endtask

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    check(ovTick == 0 && bitTick == 0, "R7 outputs in reset", {ovTick, bitTick}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(ovTick == 0 && bitTick == 0, "R7 outputs after reset", {ovTick, bitTick}, 0);
    running = 1;

    // R1, R9: 0x18A = 24.625, bit = 394 cycles; stop partway through second bit
    startRun(16'h18A, 1);
    waitUntil(origin + 494);
    stopRun();
    quietCheck(40, "R5 tick while disabled");

    // R5: restart is a fresh phase; R6/R8: switch to 0x010 at a bit edge
    startRun(16'h18A, 2);
    begin
      int e;
      e = origin + 2 * 394;
      waitUntil(e - 1);
      divReg  = 16'h010;
      nextDiv = 16;
      pending = 1;
      for (int k = 1; k <= 3; k++) expQ.push_back(e + k * 16);
      waitUntil(e + 48);
    end
    stopRun();
    quietCheck(20, "R5 tick while disabled");

    // R6: one-cycle divisor glitch between ticks is ignored
    startRun(16'h100, 2);
    waitUntil(origin + 21);
    divReg = 16'h013;
    @(negedge clk);
    divReg = 16'h100;
    waitUntil(origin + 512);
    stopRun();

    // R4: words below 16 produce nothing
    divReg = 16'h00F;
    @(negedge clk);
    enable = 1'b1;
    quietCheck(150, "R4 tick with divisor 0x00F");
    divReg = 16'h000;
    quietCheck(60, "R4 tick with divisor 0x000");
    stopRun();

    // R9: 0x271 = 39.0625, bit = 625 cycles
    startRun(16'h271, 2);
    waitUntil(origin + 1250);
    stopRun();

    check(expQ.size() == 0, "R3 missing bitTicks", expQ.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule